// File: doc/BRIEF.md
# Chip-Select Output Bank

This block drives a small bank of output pins, three or six depending on a parameter. Each pin can serve either as a plain general-purpose output or as a device chip select. Every pin is controlled by one state bit. Software changes that bit through a write-only drive word. In the drive word, one byte carries set strobes and the other byte carries clear strobes. Because of this, any subset of pins can be raised or lowered in one write without first reading the current value.

A configuration word holds two bits per pin. The mode bit moves the pin's level into the chip-select half of the status word. The inversion bit flips the level on the pin, which suits devices that select on a high level. After reset, and again after the usual start-up sequence, every state bit is one, and with no inversion that is the inactive level of an active-low select. Chip select number k (counting from 1) uses pin index k-1.

Top module: `csel_bank`

## Requirements
- R1: After reset every internal state bit is 1 and every configuration bit is 0, so `pin_out` is all ones, `status_word` bits [NUM_CS-1:0] are 1 and all its other bits are 0.
- R2: A drive write with bit 8+n set makes pin n's state 1 from the next cycle; chip select k (from 1) is pin index k-1.
- R3: A drive write with bit n set and bit 8+n clear makes pin n's state 0 from the next cycle.
- R4: When bits 8+n and n are both set in one drive write, pin n's state becomes 1.
- R5: Drive bits written as zero, and cycles with no drive write, leave the state of the pins they address unchanged.
- R6: Configuration bit n inverts pin n: `pin_out[n]` equals state n XOR inversion bit n, from the cycle after the configuration write.
- R7: Configuration bit 8+n places pin n in chip-select mode. `status_word[8+n]` then carries the pin level and `status_word[n]` reads 0. Otherwise `status_word[n]` carries the level and `status_word[8+n]` reads 0. Both modes respond to the drive word in the same way.
- R8: Drive and configuration bits for pin indices at or above NUM_CS (bits 15:8+NUM_CS and 7:NUM_CS) have no effect, and status bits for those indices read 0.
- R9: The start-up sequence, a configuration write of 0x0000 followed by a drive write of 0xFF00, returns every pin to level 1 regardless of the earlier state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word: bits 8+n mode, bits n inversion |
| drv_wr | input | 1 | Drive word write strobe |
| drv_wdata | input | 16 | Drive word: bits 8+n set, bits n clear |
| pin_out | output | NUM_CS | Pin levels |
| status_word | output | 16 | Levels split by mode: bits 8+n chip-select pins, bits n general-purpose pins |

## Verification
The hardest case to reach is a write whose set and clear bytes overlap in arbitrary patterns while pins sit in mixed modes and mixed polarities. If only simple patterns are tested, a wrong priority or a swapped byte stays hidden. The stimulus therefore sweeps all 4096 combinations of the in-range set and clear bits. The unused bit positions in those words carry values derived from the sweep index. Before this sweep, it walks all 64 inversion patterns, each paired with a rotated mode pattern. The expected pin and status values come from a small arithmetic model in the bench.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
   localparam int WORD_W = 16;
   localparam int HALF_W = 8;
   localparam int MAX_PINS = 8;
endpackage

// File: rtl/csel_cfg_reg.sv
`timescale 1ns/1ps
module csel_cfg_reg
   import csel_pkg::*;
#(
   parameter int N = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   output logic [N-1:0]      mode_cs,
   output logic [N-1:0]      invert
);
   localparam int HI_LSB = HALF_W;

   // bits outside the pin range are dropped
   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{wdata[WORD_W-1:HI_LSB+N], wdata[HALF_W-1:N]};

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_cs[i] <= 1'b0;
            invert[i]  <= 1'b0;
         end else if (wr) begin
            mode_cs[i] <= wdata[HI_LSB+i];
            invert[i]  <= wdata[i];
         end
      end
   end
endmodule

// File: rtl/csel_drive_state.sv
`timescale 1ns/1ps
module csel_drive_state
   import csel_pkg::*;
#(
   parameter int N = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   output logic [N-1:0]      state
);
   localparam int HI_LSB = HALF_W;

   logic [N-1:0] set_hit;
   logic [N-1:0] clr_hit;

   logic unused_drv_bits;
   assign unused_drv_bits = ^{wdata[WORD_W-1:HI_LSB+N], wdata[HALF_W-1:N]};

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign set_hit[i] = wr & wdata[HI_LSB+i];
      assign clr_hit[i] = wr & wdata[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          state[i] <= 1'b1;
         else if (set_hit[i]) state[i] <= 1'b1;
         else if (clr_hit[i]) state[i] <= 1'b0;
      end

      assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && wdata[HI_LSB+i]) |=> state[i]);
      assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && wdata[i] && !wdata[HI_LSB+i]) |=> !state[i]);
      assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && wdata[i] && wdata[HI_LSB+i]) |=> state[i]);
      assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr && (wdata[i] || wdata[HI_LSB+i])) |=> $stable(state[i]));
   end
endmodule

// File: rtl/csel_pin_map.sv
`timescale 1ns/1ps
module csel_pin_map
   import csel_pkg::*;
#(
   parameter int N = 6
) (
   input  logic [N-1:0]      state,
   input  logic [N-1:0]      invert,
   input  logic [N-1:0]      mode_cs,
   output logic [N-1:0]      level,
   output logic [WORD_W-1:0] status
);
   localparam int HI_LSB = HALF_W;

   for (genvar i = 0; i < HALF_W; i++) begin : g_pin
      if (i < N) begin : g_live
         assign level[i]         = state[i] ^ invert[i];
         assign status[HI_LSB+i] = mode_cs[i] & level[i];
         assign status[i]        = ~mode_cs[i] & level[i];
      end else begin : g_tie
         assign status[HI_LSB+i] = 1'b0;
         assign status[i]        = 1'b0;
      end
   end

   always_comb begin
      assert_split_R7: assert ($countones(status) == $countones(level));
   end
endmodule

// File: rtl/csel_bank.sv
`timescale 1ns/1ps
module csel_bank
   import csel_pkg::*;
#(
   parameter int NUM_CS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [15:0]       cfg_wdata,
   input  logic              drv_wr,
   input  logic [15:0]       drv_wdata,
   output logic [NUM_CS-1:0] pin_out,
   output logic [15:0]       status_word
);
   if (!(NUM_CS == 3 || NUM_CS == 6)) begin : g_bad_count
      $error("csel_bank: NUM_CS must be 3 or 6");
   end
   if (NUM_CS > MAX_PINS) begin : g_too_wide
      $error("csel_bank: NUM_CS exceeds one byte of strobes");
   end

   logic [NUM_CS-1:0] st;
   logic [NUM_CS-1:0] inv;
   logic [NUM_CS-1:0] mode;

   csel_cfg_reg #(.N(NUM_CS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
      .mode_cs(mode), .invert(inv)
   );

   csel_drive_state #(.N(NUM_CS)) u_drv (
      .clk(clk), .rst_n(rst_n), .wr(drv_wr), .wdata(drv_wdata),
      .state(st)
   );

   csel_pin_map #(.N(NUM_CS)) u_map (
      .state(st), .invert(inv), .mode_cs(mode),
      .level(pin_out), .status(status_word)
   );

   assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && !drv_wr) |=> $stable(pin_out));
   assert_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !drv_wr) |=> (pin_out ^ $past(pin_out)) ==
                              (inv ^ $past(inv)));
   assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[15:8+NUM_CS] == '0);
endmodule

// File: tb/csel_bank_tb.sv
`timescale 1ns/1ps
module csel_bank_tb;
   localparam int N = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        drv_wr = 1'b0;
   logic [15:0] drv_wdata = '0;
   logic [N-1:0] pin_out;
   logic [15:0]  status_word;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [N-1:0] m_state;
   logic [N-1:0] m_inv;
   logic [N-1:0] m_sel;

   always #5 clk = ~clk;

   csel_bank #(.NUM_CS(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .drv_wr(drv_wr), .drv_wdata(drv_wdata),
      .pin_out(pin_out), .status_word(status_word)
   );

   function automatic logic [15:0] exp_status();
      logic [15:0] s = '0;
      for (int i = 0; i < N; i++) begin
         if (m_sel[i]) s[8+i] = m_state[i] ^ m_inv[i];
         else          s[i]   = m_state[i] ^ m_inv[i];
      end
      return s;
   endfunction

   task automatic check(input string tag);
      logic [N-1:0] ep = m_state ^ m_inv;
      logic [15:0]  es = exp_status();
      n_tests++;
      if (pin_out !== ep || status_word !== es) begin
         n_fail++;
         $display("FAIL %s: pin_out=%b status=%h expected pin_out=%b status=%h",
                  tag, pin_out, status_word, ep, es);
      end
   endtask

   function automatic void model_drive(input logic [15:0] w);
      for (int i = 0; i < N; i++) begin
         if (w[8+i])   m_state[i] = 1'b1;
         else if (w[i]) m_state[i] = 1'b0;
      end
   endfunction

   task automatic write_drv(input logic [15:0] w);
      @(negedge clk);
      drv_wr = 1'b1; drv_wdata = w;
      @(negedge clk);
      drv_wr = 1'b0; drv_wdata = '0;
      model_drive(w);
   endtask

   task automatic write_cfg(input logic [15:0] w);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = w;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wdata = '0;
      m_sel = w[8 +: N];
      m_inv = w[N-1:0];
   endtask

   initial begin
      m_state = '1; m_inv = '0; m_sel = '0;
      repeat (3) @(negedge clk);
      check("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release");

      // chip select k=2 -> index 1
      write_drv(16'h003F);
      check("R3 clear all");
      write_drv(16'h0200);
      check("R2 chip select 2 on index 1");
      write_drv(16'h3F3F);
      check("R4 set wins over clear");
      write_drv(16'h0000);
      check("R5 zero write");
      write_drv(16'h0005);
      repeat (5) @(negedge clk);
      check("R5 idle cycles");

      // R8: out-of-range bits only
      write_drv(16'hC0C0);
      check("R8 drive bits above range");
      write_cfg(16'hC0C0);
      check("R8 cfg bits above range");

      // R6 / R7: all inversion patterns with rotated mode patterns
      for (int p = 0; p < 64; p++) begin
         logic [5:0] sp = 6'((p << 2) | (p >> 4));
         write_cfg({2'b00, sp, 2'b00, 6'(p)});
         check("R6 R7 cfg sweep");
         write_drv({2'b00, 6'(p ^ 6'h2A), 2'b00, 6'(~p)});
         check("R7 drive under mixed modes");
      end

      // simultaneous config and drive writes
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = 16'h0F33;
      drv_wr = 1'b1; drv_wdata = 16'h1122;
      @(negedge clk);
      cfg_wr = 1'b0; drv_wr = 1'b0;
      m_sel = 6'h0F; m_inv = 6'h33; model_drive(16'h1122);
      check("R6 cfg and drive same cycle");

      // exhaustive in-range set/clear sweep with junk in unused bits
      write_cfg(16'h2A15);
      for (int v = 0; v < 4096; v++) begin
         logic [15:0] w = {2'(v), 6'(v >> 6), 2'(v >> 3), 6'(v)};
         write_drv(w);
         check("R2 R3 R4 R8 drive sweep");
      end

      // R9 start-up sequence
      write_drv(16'h003F);
      write_cfg(16'h0000);
      write_drv(16'hFF00);
      check("R9 start-up sequence");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule